// File: doc/BRIEF.md
# Armed Bulk-Erase Command Guard

This controller sits between the downlink frame decoder of a contactless tag and the nonvolatile-memory erase engine. It holds back a destructive "wipe the whole memory" command until a separate arming command has been accepted. Arming is accepted only while the tag is selected and the key field carried by the arming command is not the locked value 6. The arming is single-use and fragile. The very next command must be the clear command, otherwise the armed state is lost.

When an armed clear arrives, the block asks the erase engine to wipe the data and lock bits of every block except the factory traceability blocks. It also bounds the programming time with a cycle counter sized for 6 ms at the configured clock. It then asks the uplink side for a response. A success is reported as a bare start-of-frame. Any failure is reported as a start-of-frame followed by a 4-bit error code, which the uplink encoder sends with dual-pattern coding.

The decoder delivers each command as a one-cycle pulse on `cmd_valid`, with the opcode bits right-aligned in `cmd_bits` and the opcode length in `cmd_len`.

Top module: `erase_guard_ctrl`

## Requirements
- R1: After a synchronous reset, `ers_req`, `ers_mask` and `rsp_valid` are 0 and the block is disarmed, so a clear command gets the not-armed error.
- R2: An arm command sets the armed state when it is sampled while `tag_selected` is 1 and `cmd_key` is not 6. An arm command is `cmd_len` = 10 with `cmd_bits` = 10'b0011001000. A clear command sampled next, with `cmd_len` = 4 and `cmd_bits[3:0]` = 4'b0001, raises `ers_req` in the following cycle. A second arm in place of the first also leaves the block armed.
- R3: An arm command carrying `cmd_key` = 6 does not arm the block.
- R4: Any command other than the clear command that arrives after arming drops the armed state.
- R5: The armed state is dropped whenever `tag_selected` is 0. An arm command received while not selected does not arm.
- R6: While `ers_req` is 1, `ers_mask` has a 1 for every block except those marked in the traceability mask, and it does not change. It is 0 while no erase runs.
- R7: If `ers_done` is sampled while `ers_req` is 1, then `ers_req` drops in the next cycle. In that same cycle `rsp_valid` pulses for one cycle with `rsp_err` = 0 and `rsp_code` = 0, which means start-of-frame only.
- R8: If `ers_fail` is sampled while `ers_req` is 1 and `ers_done` is 0, the erase ends and the response carries `rsp_err` = 1 and `rsp_code` = 4'h8.
- R9: If neither `ers_done` nor `ers_fail` arrives, `ers_req` stays high for exactly CLK_HZ/1000*PROG_MS cycles. It then drops, and the response carries `rsp_code` = 4'h4.
- R10: A clear command with `cmd_crc_present` = 1 and `cmd_crc_ok` = 0 produces an error response with `rsp_code` = 4'h1 in the next cycle. No erase starts, even when the block is armed.
- R11: A clear command received while not armed or not selected starts no erase and returns `rsp_code` = 4'h2. The armed state is cleared after every clear command, whatever its outcome.
- R12: Commands that arrive while an erase runs are ignored. They produce no response and do not change the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command is present |
| cmd_bits | input | 10 | Opcode bits, right-aligned |
| cmd_len | input | 4 | Number of opcode bits |
| cmd_key | input | 4 | Key field carried by the arm command |
| cmd_crc_present | input | 1 | Downlink CRC was appended |
| cmd_crc_ok | input | 1 | Appended CRC checked good |
| tag_selected | input | 1 | Tag is in the selected state |
| ers_req | output | 1 | Erase request to the memory engine, held until the end |
| ers_mask | output | NUM_BLOCKS | Blocks whose data and lock bits are to be erased |
| ers_done | input | 1 | Erase engine finished successfully |
| ers_fail | input | 1 | Erase engine reported a programming failure |
| rsp_valid | output | 1 | One-cycle request for an uplink response |
| rsp_err | output | 1 | 1: the response carries an error code |
| rsp_code | output | 4 | Error code (0 success, 1 CRC, 2 not armed, 4 timeout, 8 program) |

## Verification
The bench builds the block with CLK_HZ = 10000 and PROG_MS = 6. The timeout window therefore shrinks to 60 cycles, and the bench can measure the full length of a stalled erase and count the exact `ers_req` high time. It uses NUM_BLOCKS = 8 with the two lowest blocks protected, so the expected mask 8'hFC is easy to compare against. With these values the bench can also run many arm and disarm sequences, engine failures and commands that arrive during an erase, all within a short run.

// File: rtl/erase_guard_pkg.sv
package erase_guard_pkg;

  localparam int          OPW          = 10;
  localparam logic [9:0]  OP_ARM       = 10'b0011001000;
  localparam logic [3:0]  OP_ARM_LEN   = 4'd10;
  localparam logic [3:0]  OP_CLR       = 4'b0001;
  localparam logic [3:0]  OP_CLR_LEN   = 4'd4;
  localparam logic [3:0]  KEY_BLOCKED  = 4'd6;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'h0,
    ERR_CRC       = 4'h1,
    ERR_NOT_ARMED = 4'h2,
    ERR_TIMEOUT   = 4'h4,
    ERR_PROG      = 4'h8
  } err_code_e;

  typedef enum logic {SEQ_IDLE, SEQ_ERASE} seq_state_e;

  typedef struct packed {
    logic      fire;
    logic      err;
    err_code_e code;
  } rsp_evt_t;

  function automatic logic op_is_arm(input logic [OPW-1:0] b, input logic [3:0] l);
    return (l == OP_ARM_LEN) && (b == OP_ARM);
  endfunction

  function automatic logic op_is_clear(input logic [OPW-1:0] b, input logic [3:0] l);
    return (l == OP_CLR_LEN) && (b[3:0] == OP_CLR);
  endfunction

endpackage

// File: rtl/egc_arm_tracker.sv
module egc_arm_tracker
  import erase_guard_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           take,
  input  logic [OPW-1:0] bits,
  input  logic [3:0]     len,
  input  logic [3:0]     key,
  input  logic           selected,
  output logic           armed
);

  // Each accepted command either re-arms (valid arm) or disarms.
  always_ff @(posedge clk) begin
    if (rst || !selected) begin
      armed <= 1'b0;
    end else if (take) begin
      armed <= op_is_arm(bits, len) && (key != KEY_BLOCKED);
    end
  end

endmodule

// File: rtl/egc_erase_seq.sv
module egc_erase_seq
  import erase_guard_pkg::*;
#(
  parameter int                    NUM_BLOCKS = 32,
  parameter logic [NUM_BLOCKS-1:0] TRACE_MASK = '0,
  parameter int                    TMO_CYC    = 6000
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take_clr,
  input  logic                  crc_bad,
  input  logic                  armed,
  input  logic                  selected,
  input  logic                  ers_done,
  input  logic                  ers_fail,
  output logic                  busy,
  output logic [NUM_BLOCKS-1:0] ers_mask,
  output rsp_evt_t              evt
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYC - 1);
  localparam logic [NUM_BLOCKS-1:0] WIPE_MASK = ~TRACE_MASK;

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          start;

  assign busy  = (state == SEQ_ERASE);
  assign start = (state == SEQ_IDLE) && take_clr && !crc_bad && armed && selected;

  always_comb begin
    evt = '{fire: 1'b0, err: 1'b0, code: ERR_NONE};
    if (state == SEQ_IDLE) begin
      if (take_clr && crc_bad)
        evt = '{fire: 1'b1, err: 1'b1, code: ERR_CRC};
      else if (take_clr && !(armed && selected))
        evt = '{fire: 1'b1, err: 1'b1, code: ERR_NOT_ARMED};
    end else begin
      if (ers_done)
        evt = '{fire: 1'b1, err: 1'b0, code: ERR_NONE};
      else if (ers_fail)
        evt = '{fire: 1'b1, err: 1'b1, code: ERR_PROG};
      else if (cnt == CNT_LAST)
        evt = '{fire: 1'b1, err: 1'b1, code: ERR_TIMEOUT};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      cnt      <= '0;
      ers_mask <= '0;
    end else if (state == SEQ_IDLE) begin
      cnt <= '0;
      if (start) begin
        state    <= SEQ_ERASE;
        ers_mask <= WIPE_MASK;
      end
    end else if (evt.fire) begin
      state    <= SEQ_IDLE;
      ers_mask <= '0;
      cnt      <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/egc_rsp_reg.sv
module egc_rsp_reg
  import erase_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rsp_evt_t evt,
  output logic     rsp_valid,
  output logic     rsp_err,
  output logic [3:0] rsp_code
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= evt.fire;
      rsp_err   <= evt.fire && evt.err;
      rsp_code  <= evt.fire ? evt.code : ERR_NONE;
    end
  end

endmodule

// File: rtl/erase_guard_ctrl.sv
module erase_guard_ctrl
  import erase_guard_pkg::*;
#(
  parameter int                    NUM_BLOCKS = 32,
  parameter logic [NUM_BLOCKS-1:0] TRACE_MASK = NUM_BLOCKS'(3),
  parameter int                    CLK_HZ     = 1_000_000,
  parameter int                    PROG_MS    = 6
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [9:0]            cmd_bits,
  input  logic [3:0]            cmd_len,
  input  logic [3:0]            cmd_key,
  input  logic                  cmd_crc_present,
  input  logic                  cmd_crc_ok,
  input  logic                  tag_selected,
  output logic                  ers_req,
  output logic [NUM_BLOCKS-1:0] ers_mask,
  input  logic                  ers_done,
  input  logic                  ers_fail,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [3:0]            rsp_code
);

  localparam int TMO_CYC = (CLK_HZ / 1000) * PROG_MS;

  logic     busy;
  logic     take;
  logic     armed;
  rsp_evt_t evt;

  // Commands are only accepted while no erase is running (R12).
  assign take    = cmd_valid && !busy;
  assign ers_req = busy;

  egc_arm_tracker u_arm (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .bits     (cmd_bits),
    .len      (cmd_len),
    .key      (cmd_key),
    .selected (tag_selected),
    .armed    (armed)
  );

  egc_erase_seq #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .TRACE_MASK (TRACE_MASK),
    .TMO_CYC    (TMO_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .take_clr (take && op_is_clear(cmd_bits, cmd_len)),
    .crc_bad  (cmd_crc_present && !cmd_crc_ok),
    .armed    (armed),
    .selected (tag_selected),
    .ers_done (ers_done),
    .ers_fail (ers_fail),
    .busy     (busy),
    .ers_mask (ers_mask),
    .evt      (evt)
  );

  egc_rsp_reg u_rsp (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_code  (rsp_code)
  );

endmodule

// File: rtl/erase_guard_chk.sv
module erase_guard_chk
  import erase_guard_pkg::*;
#(
  parameter int                    NUM_BLOCKS = 32,
  parameter logic [NUM_BLOCKS-1:0] TRACE_MASK = '0,
  parameter int                    TMO_CYC    = 6000
)(
  input logic                  clk,
  input logic                  rst,
  input logic                  cmd_valid,
  input logic [9:0]            cmd_bits,
  input logic [3:0]            cmd_len,
  input logic                  cmd_crc_present,
  input logic                  cmd_crc_ok,
  input logic                  ers_req,
  input logic [NUM_BLOCKS-1:0] ers_mask,
  input logic                  ers_done,
  input logic                  ers_fail,
  input logic                  rsp_valid,
  input logic                  rsp_err,
  input logic [3:0]            rsp_code
);

  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] req_cycles;

  always_ff @(posedge clk) begin
    if (rst || !ers_req) req_cycles <= '0;
    else                 req_cycles <= req_cycles + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!ers_req && !rsp_valid && ers_mask == '0));

  a_r6_trace_kept: assert property (@(posedge clk) disable iff (rst)
    ers_req |-> ((ers_mask & TRACE_MASK) == '0) && (ers_mask != '0));

  a_r6_mask_stable: assert property (@(posedge clk) disable iff (rst)
    (ers_req && $past(ers_req)) |-> $stable(ers_mask));

  a_r7_done_ends: assert property (@(posedge clk) disable iff (rst)
    (ers_req && ers_done) |=> (!ers_req && rsp_valid && !rsp_err && rsp_code == 4'h0));

  a_r8_fail_code: assert property (@(posedge clk) disable iff (rst)
    (ers_req && !ers_done && ers_fail) |=> (!ers_req && rsp_valid && rsp_err && rsp_code == 4'h8));

  a_r9_window: assert property (@(posedge clk) disable iff (rst)
    ers_req |-> (req_cycles < CW'(TMO_CYC)));

  a_r10_crc_abort: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !ers_req && op_is_clear(cmd_bits, cmd_len) && cmd_crc_present && !cmd_crc_ok)
      |=> (rsp_valid && rsp_err && rsp_code == 4'h1 && !ers_req));

  a_r11_nack_no_erase: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 4'h2) |-> !ers_req);

endmodule

bind erase_guard_ctrl erase_guard_chk #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .TRACE_MASK (TRACE_MASK),
  .TMO_CYC    (TMO_CYC)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cmd_valid       (cmd_valid),
  .cmd_bits        (cmd_bits),
  .cmd_len         (cmd_len),
  .cmd_crc_present (cmd_crc_present),
  .cmd_crc_ok      (cmd_crc_ok),
  .ers_req         (ers_req),
  .ers_mask        (ers_mask),
  .ers_done        (ers_done),
  .ers_fail        (ers_fail),
  .rsp_valid       (rsp_valid),
  .rsp_err         (rsp_err),
  .rsp_code        (rsp_code)
);

// File: tb/test_erase_guard_ctrl.sv
module test_erase_guard_ctrl;

  localparam int NB = 8;
  localparam logic [NB-1:0] TMASK = 8'h03;
  localparam int TMO = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [9:0] cmd_bits = '0;
  logic [3:0] cmd_len = '0;
  logic [3:0] cmd_key = '0;
  logic cmd_crc_present = 1'b0;
  logic cmd_crc_ok = 1'b0;
  logic tag_selected = 1'b1;
  logic ers_req;
  logic [NB-1:0] ers_mask;
  logic ers_done = 1'b0;
  logic ers_fail = 1'b0;
  logic rsp_valid, rsp_err;
  logic [3:0] rsp_code;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [4:0] expq[$];
  string      tagq[$];

  always #2.5 clk = ~clk;

  erase_guard_ctrl #(
    .NUM_BLOCKS (NB),
    .TRACE_MASK (TMASK),
    .CLK_HZ     (10_000),
    .PROG_MS    (6)
  ) i_erase_guard_ctrl (
    .clk (clk), .rst (rst),
    .cmd_valid (cmd_valid), .cmd_bits (cmd_bits), .cmd_len (cmd_len),
    .cmd_key (cmd_key), .cmd_crc_present (cmd_crc_present), .cmd_crc_ok (cmd_crc_ok),
    .tag_selected (tag_selected),
    .ers_req (ers_req), .ers_mask (ers_mask), .ers_done (ers_done), .ers_fail (ers_fail),
    .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_code (rsp_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_rsp(input logic err, input logic [3:0] code, input string req);
    expq.push_back({err, code});
    tagq.push_back(req);
  endtask

  // Monitor: compares every response against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R12 unexpected response", {27'd0, rsp_err, rsp_code}, 0);
      end else begin
        logic [4:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({rsp_err, rsp_code} == e, t, {27'd0, rsp_err, rsp_code}, {27'd0, e});
      end
    end
  end

  task automatic send(input logic [9:0] b, input logic [3:0] l, input logic [3:0] k,
                      input logic cp, input logic co);
    cmd_bits = b; cmd_len = l; cmd_key = k;
    cmd_crc_present = cp; cmd_crc_ok = co;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic arm(input logic [3:0] k);
    send(10'b0011001000, 4'd10, k, 1'b0, 1'b0);
  endtask

  task automatic clear(input logic cp, input logic co);
    send(10'b0000000001, 4'd4, 4'd0, cp, co);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_done(input string req);
    ers_done = 1'b1;
    @(negedge clk);
    ers_done = 1'b0;
    chk(ers_req == 1'b0, req, ers_req, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk(ers_req == 1'b0, "R1 ers_req after reset", ers_req, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(ers_mask == '0, "R1 ers_mask after reset", ers_mask, 0);
    expect_rsp(1'b1, 4'h2, "R1 clear after reset is not armed");
    clear(1'b0, 1'b0);
    idle(2);

    // R2 / R6 / R7: armed clear succeeds
    arm(4'd0);
    expect_rsp(1'b0, 4'h0, "R7 success response");
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b1, "R2 erase starts after armed clear", ers_req, 1);
    chk(ers_mask == 8'hFC, "R6 mask skips traceability", ers_mask, 8'hFC);
    idle(3);
    chk(ers_req == 1'b1, "R2 erase held", ers_req, 1);
    chk(ers_mask == 8'hFC, "R6 mask stable", ers_mask, 8'hFC);
    finish_done("R7 request drops after done");
    chk(ers_mask == '0, "R6 mask cleared when idle", ers_mask, 0);
    idle(1);
    // R11: armed state consumed by the clear
    expect_rsp(1'b1, 4'h2, "R11 second clear is not armed");
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b0, "R11 no erase on second clear", ers_req, 0);
    idle(2);

    // R3: key value 6 refuses arming
    arm(4'd6);
    expect_rsp(1'b1, 4'h2, "R3 key 6 does not arm");
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b0, "R3 no erase", ers_req, 0);
    idle(2);

    // R4: intervening command disarms
    arm(4'd1);
    send(10'b0000110000, 4'd6, 4'd0, 1'b0, 1'b0);
    expect_rsp(1'b1, 4'h2, "R4 intervening command disarms");
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b0, "R4 no erase", ers_req, 0);
    idle(2);

    // R2 repeated arm stays armed; R8 engine failure
    arm(4'd2);
    arm(4'd3);
    expect_rsp(1'b1, 4'h8, "R8 program failure code");
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b1, "R2 double arm still armed", ers_req, 1);
    ers_fail = 1'b1;
    @(negedge clk);
    ers_fail = 1'b0;
    chk(ers_req == 1'b0, "R8 request drops after fail", ers_req, 0);
    idle(2);

    // R5: arm while not selected
    tag_selected = 1'b0;
    arm(4'd0);
    tag_selected = 1'b1;
    expect_rsp(1'b1, 4'h2, "R5 arm while deselected ignored");
    clear(1'b0, 1'b0);
    idle(2);
    // R5: deselect after arming
    arm(4'd0);
    tag_selected = 1'b0;
    idle(1);
    tag_selected = 1'b1;
    expect_rsp(1'b1, 4'h2, "R5 deselect disarms");
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b0, "R5 no erase", ers_req, 0);
    idle(2);
    // R11: clear while not selected
    arm(4'd0);
    tag_selected = 1'b0;
    expect_rsp(1'b1, 4'h2, "R11 clear while deselected");
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b0, "R11 no erase while deselected", ers_req, 0);
    tag_selected = 1'b1;
    idle(2);

    // R10: bad CRC aborts even when armed
    arm(4'd0);
    expect_rsp(1'b1, 4'h1, "R10 bad CRC error");
    clear(1'b1, 1'b0);
    chk(ers_req == 1'b0, "R10 no erase on bad CRC", ers_req, 0);
    expect_rsp(1'b1, 4'h2, "R11 armed state cleared by aborted clear");
    clear(1'b1, 1'b1);
    idle(2);
    arm(4'd0);
    expect_rsp(1'b0, 4'h0, "R10 good CRC allows erase");
    clear(1'b1, 1'b1);
    chk(ers_req == 1'b1, "R10 good CRC starts erase", ers_req, 1);
    finish_done("R7 request drops after done");
    idle(2);

    // R9: timeout window
    arm(4'd0);
    expect_rsp(1'b1, 4'h4, "R9 timeout code");
    clear(1'b0, 1'b0);
    begin
      int n;
      n = 0;
      while (ers_req && n < 200) begin
        n++;
        @(negedge clk);
      end
      chk(n == TMO, "R9 request high cycles", n, TMO);
    end
    idle(2);

    // R12: commands during erase are ignored
    arm(4'd0);
    expect_rsp(1'b0, 4'h0, "R12 erase completes normally");
    clear(1'b0, 1'b0);
    arm(4'd0);
    clear(1'b1, 1'b0);
    clear(1'b0, 1'b0);
    chk(ers_req == 1'b1, "R12 erase not disturbed", ers_req, 1);
    finish_done("R12 request drops after done");
    expect_rsp(1'b1, 4'h2, "R12 arm during erase ignored");
    clear(1'b0, 1'b0);
    idle(4);

    chk(expq.size() == 0, "R12 all expected responses seen", expq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule